// File: doc/BRIEF.md
# Shared Interrupt Priority Router

This block selects, for every processing element in a cluster, the most urgent shared peripheral interrupt that is waiting for it. It holds per-interrupt state: pending, enabled, active, group, priority and a routing word. Any change to that state starts a re-evaluation pass. A pass walks the shared interrupt lines one per clock. For each line that may be delivered, it works out which element the line routes to. If the line beats that element's best-pending record, the record is replaced. A line can route to an explicit packed affinity, or to the lowest-numbered element that accepts one-of-N delivery for the line's group.

Records are never cleared wholesale at the start of a pass. A record only gets worse through an explicit invalidation: a deassert or software clear of a line empties the record of the element that line routes to, and an activation empties the record of the element that took the interrupt. Each invalidation queues a fresh pass, so the next best line can surface. A line whose routing matches no element is skipped and keeps its pending bit, and it is picked up once its routing becomes valid.

Top module: `spi_prio_router`

## Requirements
- R1: Out of reset every element record shows priority all-ones (0xFF, meaning nothing pending), `scanBusy` and `scanDone` are low.
- R2: A line is a candidate only while it is pending, enabled, not active and its group's bit in `grpEnable` (bit 0 for group 0, bit 1 for group 1) is set; a change of `grpEnable` starts a pass.
- R3: A candidate replaces an element record when its priority value is numerically lower, or equal with a lower interrupt ID.
- R4: In targeted mode (`cfgAnyPe`=0) a line goes to the element whose 32-bit affinity word equals the line's routing word, packed Aff3 in bits 31:24, Aff2 in 23:16, Aff1 in 15:8, Aff0 in 7:0; if several match, the lowest-numbered one.
- R5: In any-element mode (`cfgAnyPe`=1) a line goes to the lowest-numbered element whose willing bit `peWilling[2*pe+group]` is set.
- R6: A line that routes to no element changes no record and stays pending; it is delivered after its routing is made valid.
- R7: A deassert, or a software clear (`swPendSet`=0), of a line sets the priority of the record of the element it routes to to all-ones in the next cycle and starts a pass.
- R8: An activate marks the line active and sets the priority of record `actPe` to all-ones in the next cycle; a deactivate makes the line a candidate again after the following pass.
- R9: A pass evaluates one line per clock, keeping `scanBusy` high for exactly NUM_LINES-32 cycles, then pulses `scanDone` for one cycle; a request arriving during a pass causes exactly one further pass right after it.
- R10: Except through R7 and R8 invalidations, a record's priority value never increases, and records hold while no pass runs.
- R11: Commands naming an ID below 32 or at or above NUM_LINES are ignored: no state change, no invalidation and no pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grpEnable | input | 2 | Per-group delivery enable |
| peAffinity | input | NUM_PE*32 | Packed affinity word of each element |
| peWilling | input | NUM_PE*2 | One-of-N willingness per element and group |
| cfgValid | input | 1 | Write line configuration |
| cfgId | input | ID_W | Line being configured |
| cfgEnable | input | 1 | Line enable |
| cfgGroup | input | 1 | Line group |
| cfgPrio | input | PRIO_W | Line priority, lower is more urgent |
| cfgAnyPe | input | 1 | 1 selects any-element routing |
| cfgAffinity | input | 32 | Targeted routing word |
| raiseValid | input | 1 | Peripheral asserts a line |
| raiseId | input | ID_W | Asserted line |
| lowerValid | input | 1 | Peripheral deasserts a line |
| lowerId | input | ID_W | Deasserted line |
| swPendValid | input | 1 | Software pending write |
| swPendSet | input | 1 | 1 sets, 0 clears the pending bit |
| swPendId | input | ID_W | Line written |
| actValid | input | 1 | Element takes a line |
| actId | input | ID_W | Line taken |
| actPe | input | PE_W | Element that took it |
| deactValid | input | 1 | Line completes |
| deactId | input | ID_W | Completed line |
| bestId | output | NUM_PE*ID_W | Record ID per element |
| bestPrio | output | NUM_PE*PRIO_W | Record priority per element, all-ones when empty |
| bestGroup | output | NUM_PE | Record group per element |
| scanBusy | output | 1 | A pass is running |
| scanDone | output | 1 | One-cycle pass completion pulse |

## Verification
The bench goes after the tie at equal priority, where a design preferring the higher ID or the later-scanned line would report the wrong record. It removes the winning line and expects the runner-up to surface; a design that invalidated no record, or the wrong element's record, would keep showing a stale line. It routes a line to a missing affinity and then repairs the routing, which catches a design that drops the pending bit or delivers to a default element. It also raises a line's priority value after it has been recorded, lowers out-of-range IDs, and measures the pass length with and without a mid-pass request, exposing a design that re-zeroes records each pass, obeys foreign IDs, or loses or duplicates the queued pass.

// File: rtl/spi_router_pkg.sv
package spi_router_pkg;
  // First shared-line ID: software and private lines occupy 0..31.
  localparam int FIRST_SPI = 32;
  localparam int AFF_W = 32;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic evalEn;
  } scanStrobe_t;
endpackage

// File: rtl/spi_scan_ctrl.sv
module spi_scan_ctrl
  import spi_router_pkg::*;
#(
  parameter int NUM_SPI = 32,
  localparam int IDX_W = $clog2(NUM_SPI)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             changeReq,
  output scanStrobe_t      strobe,
  output logic [IDX_W-1:0] scanIdx,
  output logic             scanBusy,
  output logic             scanDone
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SPI - 1);

  logic busyQ, queuedQ, doneQ;
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ   <= 1'b0;
      queuedQ <= 1'b0;
      doneQ   <= 1'b0;
      idxQ    <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (changeReq) begin
          busyQ <= 1'b1;
          idxQ  <= '0;
        end
      end else if (idxQ == LAST_IDX) begin
        doneQ <= 1'b1;
        idxQ  <= '0;
        if (queuedQ || changeReq) begin
          queuedQ <= 1'b0;
        end else begin
          busyQ <= 1'b0;
        end
      end else begin
        idxQ <= idxQ + 1'b1;
        if (changeReq) queuedQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.evalEn = busyQ;
  end

  assign scanIdx  = idxQ;
  assign scanBusy = busyQ;
  assign scanDone = doneQ;
endmodule

// File: rtl/spi_route_dp.sv
module spi_route_dp
  import spi_router_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_PE = 4,
  parameter int ID_W = 10,
  parameter int PRIO_W = 8,
  localparam int NUM_SPI = NUM_LINES - FIRST_SPI,
  localparam int IDX_W = $clog2(NUM_SPI),
  localparam int PE_W = $clog2(NUM_PE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  scanStrobe_t              strobe,
  input  logic [IDX_W-1:0]         scanIdx,
  input  logic [1:0]               grpEnable,
  input  logic [NUM_PE*AFF_W-1:0]  peAffinity,
  input  logic [NUM_PE*2-1:0]      peWilling,
  input  logic                     cfgValid,
  input  logic [ID_W-1:0]          cfgId,
  input  logic                     cfgEnable,
  input  logic                     cfgGroup,
  input  logic [PRIO_W-1:0]        cfgPrio,
  input  logic                     cfgAnyPe,
  input  logic [AFF_W-1:0]         cfgAffinity,
  input  logic                     raiseValid,
  input  logic [ID_W-1:0]          raiseId,
  input  logic                     lowerValid,
  input  logic [ID_W-1:0]          lowerId,
  input  logic                     swPendValid,
  input  logic                     swPendSet,
  input  logic [ID_W-1:0]          swPendId,
  input  logic                     actValid,
  input  logic [ID_W-1:0]          actId,
  input  logic [PE_W-1:0]          actPe,
  input  logic                     deactValid,
  input  logic [ID_W-1:0]          deactId,
  output logic                     changeReq,
  output logic [NUM_PE*ID_W-1:0]   bestId,
  output logic [NUM_PE*PRIO_W-1:0] bestPrio,
  output logic [NUM_PE-1:0]        bestGroup
);
  // Per-line state
  logic [NUM_SPI-1:0] pendQ, enQ, actQ, grpQ, anyQ;
  logic [PRIO_W-1:0]  prioQ [NUM_SPI];
  logic [AFF_W-1:0]   affQ  [NUM_SPI];
  logic [1:0]         grpPrevQ;

  // Per-element best-pending records
  logic [ID_W-1:0]    recId   [NUM_PE];
  logic [PRIO_W-1:0]  recPrio [NUM_PE];
  logic [NUM_PE-1:0]  recGrp;

  function automatic logic inSpi(input logic [ID_W-1:0] id);
    return (32'(id) >= 32'(FIRST_SPI)) && (32'(id) < 32'(NUM_LINES));
  endfunction

  function automatic logic [IDX_W-1:0] toSlot(input logic [ID_W-1:0] id);
    return IDX_W'(id - ID_W'(FIRST_SPI));
  endfunction

  // Returns {found, element}; lowest-numbered match wins.
  function automatic logic [PE_W:0] routeOf(input logic anyMode,
                                            input logic [AFF_W-1:0] aff,
                                            input logic grp);
    logic [PE_W:0] r;
    r = '0;
    for (int p = NUM_PE - 1; p >= 0; p--) begin
      if (anyMode ? peWilling[2*p + 32'(grp)]
                  : (peAffinity[p*AFF_W +: AFF_W] == aff))
        r = {1'b1, PE_W'(p)};
    end
    return r;
  endfunction

  logic raiseHit, lowerHit, swHit, actHit, deactHit, cfgHit, grpChanged;
  logic [IDX_W-1:0] raiseSlot, lowerSlot, swSlot, actSlot, deactSlot, cfgSlot;
  logic [PE_W:0] lowerRoute, swRoute, curRoute;
  logic [NUM_PE-1:0] killVec;
  logic curElig;
  logic [ID_W-1:0] curId;

  always_comb begin
    raiseHit  = raiseValid  && inSpi(raiseId);
    lowerHit  = lowerValid  && inSpi(lowerId);
    swHit     = swPendValid && inSpi(swPendId);
    actHit    = actValid    && inSpi(actId);
    deactHit  = deactValid  && inSpi(deactId);
    cfgHit    = cfgValid    && inSpi(cfgId);
    raiseSlot = toSlot(raiseId);
    lowerSlot = toSlot(lowerId);
    swSlot    = toSlot(swPendId);
    actSlot   = toSlot(actId);
    deactSlot = toSlot(deactId);
    cfgSlot   = toSlot(cfgId);
    grpChanged = (grpEnable != grpPrevQ);

    lowerRoute = routeOf(anyQ[lowerSlot], affQ[lowerSlot], grpQ[lowerSlot]);
    swRoute    = routeOf(anyQ[swSlot], affQ[swSlot], grpQ[swSlot]);

    killVec = '0;
    if (lowerHit && lowerRoute[PE_W]) killVec[lowerRoute[PE_W-1:0]] = 1'b1;
    if (swHit && !swPendSet && swRoute[PE_W]) killVec[swRoute[PE_W-1:0]] = 1'b1;
    if (actHit && (32'(actPe) < 32'(NUM_PE))) killVec[actPe] = 1'b1;

    changeReq = raiseHit | lowerHit | swHit | actHit | deactHit | cfgHit | grpChanged;

    curRoute = routeOf(anyQ[scanIdx], affQ[scanIdx], grpQ[scanIdx]);
    curElig  = pendQ[scanIdx] && enQ[scanIdx] && !actQ[scanIdx]
               && grpEnable[grpQ[scanIdx]];
    curId    = ID_W'(scanIdx) + ID_W'(FIRST_SPI);
  end

  // Per-line state update: clear beats set, activate beats deactivate.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendQ    <= '0;
      enQ      <= '0;
      actQ     <= '0;
      grpQ     <= '0;
      anyQ     <= '0;
      grpPrevQ <= '0;
      for (int s = 0; s < NUM_SPI; s++) begin
        prioQ[s] <= '0;
        affQ[s]  <= '0;
      end
    end else begin
      grpPrevQ <= grpEnable;
      for (int s = 0; s < NUM_SPI; s++) begin
        if (cfgHit && cfgSlot == IDX_W'(s)) begin
          enQ[s]   <= cfgEnable;
          grpQ[s]  <= cfgGroup;
          prioQ[s] <= cfgPrio;
          anyQ[s]  <= cfgAnyPe;
          affQ[s]  <= cfgAffinity;
        end
        if (actHit && actSlot == IDX_W'(s))
          actQ[s] <= 1'b1;
        else if (deactHit && deactSlot == IDX_W'(s))
          actQ[s] <= 1'b0;
        if ((lowerHit && lowerSlot == IDX_W'(s)) ||
            (swHit && !swPendSet && swSlot == IDX_W'(s)))
          pendQ[s] <= 1'b0;
        else if ((raiseHit && raiseSlot == IDX_W'(s)) ||
                 (swHit && swPendSet && swSlot == IDX_W'(s)))
          pendQ[s] <= 1'b1;
      end
    end
  end

  // Record update: invalidation wins over a same-cycle scan win.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      recGrp <= '0;
      for (int p = 0; p < NUM_PE; p++) begin
        recId[p]   <= '1;
        recPrio[p] <= '1;
      end
    end else begin
      for (int p = 0; p < NUM_PE; p++) begin
        if (killVec[p]) begin
          recPrio[p] <= '1;
        end else if (strobe.evalEn && curElig && curRoute[PE_W] &&
                     curRoute[PE_W-1:0] == PE_W'(p) &&
                     ((prioQ[scanIdx] < recPrio[p]) ||
                      (prioQ[scanIdx] == recPrio[p] && curId < recId[p]))) begin
          recId[p]   <= curId;
          recPrio[p] <= prioQ[scanIdx];
          recGrp[p]  <= grpQ[scanIdx];
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_PE; p++) begin : g_out
    assign bestId[p*ID_W +: ID_W]       = recId[p];
    assign bestPrio[p*PRIO_W +: PRIO_W] = recPrio[p];
  end
  assign bestGroup = recGrp;
endmodule

// File: rtl/spi_prio_router.sv
module spi_prio_router
  import spi_router_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_PE = 4,
  parameter int ID_W = 10,
  parameter int PRIO_W = 8,
  localparam int PE_W = $clog2(NUM_PE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               grpEnable,
  input  logic [NUM_PE*32-1:0]     peAffinity,
  input  logic [NUM_PE*2-1:0]      peWilling,
  input  logic                     cfgValid,
  input  logic [ID_W-1:0]          cfgId,
  input  logic                     cfgEnable,
  input  logic                     cfgGroup,
  input  logic [PRIO_W-1:0]        cfgPrio,
  input  logic                     cfgAnyPe,
  input  logic [31:0]              cfgAffinity,
  input  logic                     raiseValid,
  input  logic [ID_W-1:0]          raiseId,
  input  logic                     lowerValid,
  input  logic [ID_W-1:0]          lowerId,
  input  logic                     swPendValid,
  input  logic                     swPendSet,
  input  logic [ID_W-1:0]          swPendId,
  input  logic                     actValid,
  input  logic [ID_W-1:0]          actId,
  input  logic [PE_W-1:0]          actPe,
  input  logic                     deactValid,
  input  logic [ID_W-1:0]          deactId,
  output logic [NUM_PE*ID_W-1:0]   bestId,
  output logic [NUM_PE*PRIO_W-1:0] bestPrio,
  output logic [NUM_PE-1:0]        bestGroup,
  output logic                     scanBusy,
  output logic                     scanDone
);
  localparam int NUM_SPI = NUM_LINES - FIRST_SPI;
  localparam int IDX_W = $clog2(NUM_SPI);

  scanStrobe_t      strobe;
  logic [IDX_W-1:0] scanIdx;
  logic             changeReq;

  spi_scan_ctrl #(.NUM_SPI(NUM_SPI)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .changeReq(changeReq), .strobe(strobe),
    .scanIdx(scanIdx), .scanBusy(scanBusy), .scanDone(scanDone)
  );

  spi_route_dp #(.NUM_LINES(NUM_LINES), .NUM_PE(NUM_PE), .ID_W(ID_W),
                 .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .scanIdx(scanIdx),
    .grpEnable(grpEnable), .peAffinity(peAffinity), .peWilling(peWilling),
    .cfgValid(cfgValid), .cfgId(cfgId), .cfgEnable(cfgEnable),
    .cfgGroup(cfgGroup), .cfgPrio(cfgPrio), .cfgAnyPe(cfgAnyPe),
    .cfgAffinity(cfgAffinity), .raiseValid(raiseValid), .raiseId(raiseId),
    .lowerValid(lowerValid), .lowerId(lowerId), .swPendValid(swPendValid),
    .swPendSet(swPendSet), .swPendId(swPendId), .actValid(actValid),
    .actId(actId), .actPe(actPe), .deactValid(deactValid), .deactId(deactId),
    .changeReq(changeReq), .bestId(bestId), .bestPrio(bestPrio),
    .bestGroup(bestGroup)
  );
endmodule

// File: rtl/spi_prio_router_chk.sv
module spi_prio_router_chk #(
  parameter int NUM_LINES = 64,
  parameter int NUM_PE = 4,
  parameter int ID_W = 10,
  parameter int PRIO_W = 8,
  localparam int PE_W = $clog2(NUM_PE)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lowerValid,
  input logic                     swPendValid,
  input logic                     swPendSet,
  input logic                     actValid,
  input logic [ID_W-1:0]          actId,
  input logic [PE_W-1:0]          actPe,
  input logic [NUM_PE*PRIO_W-1:0] bestPrio,
  input logic                     scanBusy,
  input logic                     scanDone
);
  logic anyKill, actInRange;
  assign anyKill    = lowerValid || (swPendValid && !swPendSet) || actValid;
  assign actInRange = (32'(actId) >= 32'd32) && (32'(actId) < 32'(NUM_LINES));

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    scanDone |=> !scanDone);  // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    scanDone |-> $past(scanBusy));  // R9

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    AST_ACT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (actValid && actInRange && actPe == PE_W'(p))
      |=> (bestPrio[p*PRIO_W +: PRIO_W] == '1));  // R8
    AST_PRIO_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !anyKill |=> (bestPrio[p*PRIO_W +: PRIO_W] <=
                    $past(bestPrio[p*PRIO_W +: PRIO_W])));  // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!scanBusy && !anyKill) |=> $stable(bestPrio[p*PRIO_W +: PRIO_W]));  // R10
  end
endmodule

bind spi_prio_router spi_prio_router_chk #(
  .NUM_LINES(NUM_LINES), .NUM_PE(NUM_PE), .ID_W(ID_W), .PRIO_W(PRIO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lowerValid(lowerValid), .swPendValid(swPendValid),
  .swPendSet(swPendSet), .actValid(actValid), .actId(actId), .actPe(actPe),
  .bestPrio(bestPrio), .scanBusy(scanBusy), .scanDone(scanDone)
);

// File: tb/spi_prio_router_tb.sv
module spi_prio_router_tb;
  localparam int NUM_LINES = 64;
  localparam int NUM_PE = 4;
  localparam int ID_W = 10;
  localparam int PRIO_W = 8;
  localparam int PE_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] grpEnable = 2'b11;
  logic [NUM_PE*32-1:0] peAffinity;
  logic [NUM_PE*2-1:0] peWilling = '0;
  logic cfgValid = 0, cfgEnable = 0, cfgGroup = 0, cfgAnyPe = 0;
  logic [ID_W-1:0] cfgId = '0;
  logic [PRIO_W-1:0] cfgPrio = '0;
  logic [31:0] cfgAffinity = '0;
  logic raiseValid = 0, lowerValid = 0, swPendValid = 0, swPendSet = 0;
  logic actValid = 0, deactValid = 0;
  logic [ID_W-1:0] raiseId = '0, lowerId = '0, swPendId = '0, actId = '0, deactId = '0;
  logic [PE_W-1:0] actPe = '0;
  logic [NUM_PE*ID_W-1:0] bestId;
  logic [NUM_PE*PRIO_W-1:0] bestPrio;
  logic [NUM_PE-1:0] bestGroup;
  logic scanBusy, scanDone;

  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  // Element p carries affinity 0x0000_01pp.
  for (genvar p = 0; p < NUM_PE; p++) begin : g_aff
    assign peAffinity[p*32 +: 32] = 32'h0000_0100 + p;
  end

  spi_prio_router #(.NUM_LINES(NUM_LINES), .NUM_PE(NUM_PE), .ID_W(ID_W),
                    .PRIO_W(PRIO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .grpEnable(grpEnable), .peAffinity(peAffinity),
    .peWilling(peWilling), .cfgValid(cfgValid), .cfgId(cfgId),
    .cfgEnable(cfgEnable), .cfgGroup(cfgGroup), .cfgPrio(cfgPrio),
    .cfgAnyPe(cfgAnyPe), .cfgAffinity(cfgAffinity), .raiseValid(raiseValid),
    .raiseId(raiseId), .lowerValid(lowerValid), .lowerId(lowerId),
    .swPendValid(swPendValid), .swPendSet(swPendSet), .swPendId(swPendId),
    .actValid(actValid), .actId(actId), .actPe(actPe), .deactValid(deactValid),
    .deactId(deactId), .bestId(bestId), .bestPrio(bestPrio),
    .bestGroup(bestGroup), .scanBusy(scanBusy), .scanDone(scanDone)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] prioOf(int p);
    return 32'(bestPrio[p*PRIO_W +: PRIO_W]);
  endfunction
  function automatic logic [31:0] idOf(int p);
    return 32'(bestId[p*ID_W +: ID_W]);
  endfunction

  task automatic waitIdle();
    for (int g = 0; g < 2000 && scanBusy; g++) @(negedge clk);
  endtask

  task automatic cfgIrq(int id, bit en, bit grp, int pr, bit any, logic [31:0] aff);
    @(negedge clk);
    cfgValid = 1; cfgId = ID_W'(id); cfgEnable = en; cfgGroup = grp;
    cfgPrio = PRIO_W'(pr); cfgAnyPe = any; cfgAffinity = aff;
    @(negedge clk);
    cfgValid = 0;
    waitIdle();
  endtask

  task automatic raise(int id);
    @(negedge clk); raiseValid = 1; raiseId = ID_W'(id);
    @(negedge clk); raiseValid = 0;
    waitIdle();
  endtask

  task automatic lower(int id);
    @(negedge clk); lowerValid = 1; lowerId = ID_W'(id);
    @(negedge clk); lowerValid = 0;
    waitIdle();
  endtask

  task automatic swPend(bit setIt, int id);
    @(negedge clk); swPendValid = 1; swPendSet = setIt; swPendId = ID_W'(id);
    @(negedge clk); swPendValid = 0;
    waitIdle();
  endtask

  task automatic activate(int id, int pe);
    @(negedge clk); actValid = 1; actId = ID_W'(id); actPe = PE_W'(pe);
    @(negedge clk); actValid = 0;
    chk("R8", "record empty next cycle", prioOf(pe), 32'hFF);
    waitIdle();
  endtask

  task automatic deactivate(int id);
    @(negedge clk); deactValid = 1; deactId = ID_W'(id);
    @(negedge clk); deactValid = 0;
    waitIdle();
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    for (int p = 0; p < NUM_PE; p++) chk("R1", "reset prio", prioOf(p), 32'hFF);
    chk("R1", "reset busy", 32'(scanBusy), 0);
    chk("R1", "reset done", 32'(scanDone), 0);
    rst_n = 1;
    @(negedge clk);
    waitIdle();
  endtask

  task automatic testTargeted();
    cfgIrq(40, 1, 0, 'h20, 0, 32'h0000_0102);
    raise(40);
    chk("R4", "PE2 prio", prioOf(2), 32'h20);
    chk("R4", "PE2 id", idOf(2), 40);
    chk("R4", "PE0 untouched", prioOf(0), 32'hFF);
    chk("R4", "PE3 untouched", prioOf(3), 32'hFF);
  endtask

  task automatic testTieAndClear();
    cfgIrq(45, 1, 0, 'h10, 0, 32'h0000_0102);
    raise(45);
    chk("R3", "lower value wins", idOf(2), 45);
    cfgIrq(35, 1, 0, 'h10, 0, 32'h0000_0102);
    raise(35);
    chk("R3", "tie lower id wins", idOf(2), 35);
    chk("R3", "tie prio", prioOf(2), 32'h10);
    lower(35);
    chk("R7", "runner-up id", idOf(2), 45);
    chk("R7", "runner-up prio", prioOf(2), 32'h10);
    lower(45);
    chk("R7", "next id", idOf(2), 40);
    chk("R7", "next prio", prioOf(2), 32'h20);
    lower(40);
    chk("R7", "emptied", prioOf(2), 32'hFF);
  endtask

  task automatic testEligibility();
    cfgIrq(50, 0, 0, 'h05, 0, 32'h0000_0101);
    raise(50);
    chk("R2", "disabled not delivered", prioOf(1), 32'hFF);
    cfgIrq(50, 1, 0, 'h05, 0, 32'h0000_0101);
    chk("R2", "enabled delivered", prioOf(1), 32'h05);
    @(negedge clk); grpEnable = 2'b01;
    @(negedge clk); waitIdle();
    cfgIrq(51, 1, 1, 'h03, 0, 32'h0000_0101);
    raise(51);
    chk("R2", "group1 off keeps id", idOf(1), 50);
    @(negedge clk); grpEnable = 2'b11;
    @(negedge clk); waitIdle();
    chk("R2", "group1 on id", idOf(1), 51);
    chk("R2", "group1 on prio", prioOf(1), 32'h03);
    chk("R2", "group bit", 32'(bestGroup[1]), 1);
    lower(51);
    chk("R7", "back to 50", prioOf(1), 32'h05);
    lower(50);
    chk("R7", "PE1 empty", prioOf(1), 32'hFF);
  endtask

  task automatic testAnyMode();
    peWilling = 8'b0101_1000;  // PE1 grp1, PE2 grp0, PE3 grp0
    cfgIrq(38, 1, 0, 'h40, 1, 32'hDEAD_BEEF);
    raise(38);
    chk("R5", "grp0 lowest willing", prioOf(2), 32'h40);
    chk("R5", "PE3 skipped", prioOf(3), 32'hFF);
    cfgIrq(39, 1, 1, 'h41, 1, 32'h0);
    raise(39);
    chk("R5", "grp1 goes PE1", idOf(1), 39);
    lower(38);
    lower(39);
    chk("R5", "cleaned", prioOf(2) & prioOf(1), 32'hFF);
  endtask

  task automatic testUnroutable();
    cfgIrq(42, 1, 0, 'h08, 0, 32'h0000_0200);
    raise(42);
    for (int p = 0; p < NUM_PE; p++) chk("R6", "no delivery", prioOf(p), 32'hFF);
    cfgIrq(42, 1, 0, 'h08, 0, 32'h0000_0101);
    chk("R6", "still pending id", idOf(1), 42);
    chk("R6", "still pending prio", prioOf(1), 32'h08);
    lower(42);
  endtask

  task automatic testSwPending();
    cfgIrq(60, 1, 0, 'h30, 0, 32'h0000_0103);
    swPend(1, 60);
    chk("R7", "sw set delivered", prioOf(3), 32'h30);
    @(negedge clk); swPendValid = 1; swPendSet = 0; swPendId = 60;
    @(negedge clk); swPendValid = 0;
    chk("R7", "sw clear next cycle", prioOf(3), 32'hFF);
    waitIdle();
    chk("R7", "sw clear after pass", prioOf(3), 32'hFF);
  endtask

  task automatic testActivate();
    cfgIrq(55, 1, 0, 'h22, 0, 32'h0000_0100);
    raise(55);
    chk("R8", "delivered PE0", prioOf(0), 32'h22);
    activate(55, 0);
    chk("R8", "active not candidate", prioOf(0), 32'hFF);
    deactivate(55);
    chk("R8", "back after deactivate", prioOf(0), 32'h22);
    cfgIrq(55, 1, 0, 'h60, 0, 32'h0000_0100);
    chk("R10", "record not raised", prioOf(0), 32'h22);
    lower(55);
    chk("R10", "invalidated", prioOf(0), 32'hFF);
  endtask

  task automatic testOutOfRange();
    raise(40);
    @(negedge clk); raiseValid = 1; raiseId = 20;
    @(negedge clk); raiseValid = 0;
    chk("R11", "private id no pass", 32'(scanBusy), 0);
    @(negedge clk); lowerValid = 1; lowerId = 8;
    @(negedge clk); lowerValid = 0;
    chk("R11", "low id no pass", 32'(scanBusy), 0);
    @(negedge clk); lowerValid = 1; lowerId = 72;
    @(negedge clk); lowerValid = 0;
    chk("R11", "high id no pass", 32'(scanBusy), 0);
    chk("R11", "record kept", prioOf(2), 32'h20);
    lower(40);
  endtask

  task automatic measurePass(int secondId, output int busyCnt, output int doneCnt);
    @(negedge clk); raiseValid = 1; raiseId = 40;
    @(negedge clk); raiseValid = 0;
    busyCnt = 0; doneCnt = 0;
    for (int k = 0; k < 200; k++) begin
      if (scanBusy) busyCnt++;
      if (scanDone) doneCnt++;
      if (k == 4 && secondId != 0) begin
        raiseValid = 1; raiseId = ID_W'(secondId);
      end else begin
        raiseValid = 0;
      end
      @(negedge clk);
    end
  endtask

  task automatic testScanTiming();
    int b, d;
    measurePass(0, b, d);
    chk("R9", "single pass length", 32'(b), NUM_LINES - 32);
    chk("R9", "single done pulse", 32'(d), 1);
    lower(40);
    measurePass(45, b, d);
    chk("R9", "queued pass length", 32'(b), 2 * (NUM_LINES - 32));
    chk("R9", "queued done pulses", 32'(d), 2);
    chk("R9", "queued result", idOf(2), 45);
    lower(45);
    lower(40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testTargeted();
    testTieAndClear();
    testEligibility();
    testAnyMode();
    testUnroutable();
    testSwPending();
    testActivate();
    testOutOfRange();
    testScanTiming();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule